// File: doc/BRIEF.md
# Register-Write Serial Bus Encoder

This block produces a write-only, two-wire serial transaction without any dedicated pins. Both wires live on two bits of one 8-bit control register, and the block moves them by issuing a stream of whole-register writes. A consumer downstream applies each write to the register. Bit 0 of the register is the serial clock and bit 1 is the serial data line. The remaining bits carry a caller-supplied base pattern, so other controls held in the same register are not disturbed while the bus is toggled.

A one-cycle start request captures the base pattern and a one-byte payload. The block then emits a fixed frame: a start condition, the device byte 0x9C, a blind acknowledge slot, the sub-address byte 0x00, another acknowledge slot, the payload byte, a final acknowledge slot and a stop condition. That is 87 writes in all. Each write is offered on a valid/ready port. After a write is accepted, the port stays quiet for a programmable number of clock cycles, which sets the bus pace. A one-cycle done flag marks the end of the frame. Nothing is read back: every acknowledge is assumed.

Top module: `pi2c_reg_encoder`

## Requirements
- R1: While reset is held and right after it is released, wr_valid_o and done_o are 0.
- R2: Every offered write carries address REG_ADDR (default 0x03).
- R3: The frame opens with three writes whose low two bits (bit 1 data, bit 0 clock) are 2'b11, 2'b01 and 2'b00, in that order.
- R4: Each data bit takes three writes with low bits {d,0}, {d,1}, {d,0}, where d is the bit on bit 1. Bytes go out most significant bit first.
- R5: One frame has exactly 87 writes: start, byte 0x9C, ack, byte 0x00, ack, payload, ack, stop.
- R6: Each acknowledge slot is one bit cycle with data low: low bits 2'b00, 2'b01, 2'b00.
- R7: The frame closes with three writes whose low bits are 2'b00, 2'b01 and 2'b11.
- R8: Bits [7:2] of every write equal bits [7:2] of base_i as sampled when start was accepted. Later changes of base_i have no effect until the next frame.
- R9: After a write is accepted, wr_valid_o stays low for exactly GAP_CYCLES cycles before the next write is offered.
- R10: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and wr_data_o does not change.
- R11: done_o is high for exactly one cycle, the cycle after the last stop write is accepted.
- R12: A start request while a frame is in progress is ignored: the frame carries on unchanged, and no further write follows the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| base_i | input | DW | Pattern for the register bits other than clock and data |
| payload_i | input | 8 | Third byte of the frame |
| wr_ready_i | input | 1 | Downstream accepts the offered write |
| wr_valid_o | output | 1 | A register write is offered |
| wr_addr_o | output | AW | Register address of the write |
| wr_data_o | output | DW | Full register value to write |
| done_o | output | 1 | One-cycle pulse when a frame has been delivered |

## Verification
The bench compares every accepted write with a frame it rebuilds from the rules, so it catches three kinds of fault: a wrong clock phase inside a bit, a bit order of least significant first, and an acknowledge slot that drives the data line high. Each of these would show up as one wrong write index. It throttles wr_ready_i at random, both to measure the quiet gap after each acceptance and to catch a design that changes its data or drops valid while stalled. It changes base_i and issues a second start in the middle of a frame. A design that resamples base_i would corrupt the upper bits, and one that restarts or queues the request would emit more than 87 writes or keep writing after done. Payloads of all zeros and all ones, and a base of all ones, show whether the low two bits are really forced.

// File: rtl/pi2c_pkg.sv
package pi2c_pkg;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_BIT   = 2'd1,
    PH_ACK   = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  localparam int unsigned SLOTS_PER_BYTE  = 8;
  localparam int unsigned BYTES_PER_FRAME = 3;
  localparam logic [1:0]  LAST_STEP       = 2'd2;

  // Returns {data, clock} for a given phase and step within that phase.
  function automatic logic [1:0] line_pair(phase_t ph, logic [1:0] step, logic bitv);
    logic [1:0] pr;
    case (ph)
      PH_START: pr = (step == 2'd0) ? 2'b11 : (step == 2'd1) ? 2'b01 : 2'b00;
      PH_STOP:  pr = (step == 2'd0) ? 2'b00 : (step == 2'd1) ? 2'b01 : 2'b11;
      PH_BIT:   pr = {bitv, step == 2'd1};
      default:  pr = {1'b0, step == 2'd1};
    endcase
    return pr;
  endfunction

  // Picks the serial bit for a byte index and slot, most significant first.
  function automatic logic frame_bit(logic [1:0] byte_idx, logic [2:0] slot,
                                     logic [7:0] dev, logic [7:0] sub, logic [7:0] pay);
    logic [7:0] b;
    case (byte_idx)
      2'd0:    b = dev;
      2'd1:    b = sub;
      default: b = pay;
    endcase
    return b[3'd7 - slot];
  endfunction

endpackage

// File: rtl/pi2c_step_seq.sv
module pi2c_step_seq
  import pi2c_pkg::*;
#(
  parameter int unsigned SLOTS = SLOTS_PER_BYTE,
  parameter int unsigned BYTES = BYTES_PER_FRAME
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init_i,
  input  logic                       advance_i,
  output phase_t                     phase_o,
  output logic [1:0]                 step_o,
  output logic [$clog2(SLOTS)-1:0]   slot_o,
  output logic [$clog2(BYTES)-1:0]   byte_o,
  output logic                       last_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned BYTE_W = $clog2(BYTES);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || init_i) begin
      phase_o <= PH_START;
      step_o  <= 2'd0;
      slot_o  <= '0;
      byte_o  <= '0;
    end else if (advance_i) begin
      if (step_o != LAST_STEP) begin
        step_o <= step_o + 2'd1;
      end else begin
        step_o <= 2'd0;
        case (phase_o)
          PH_START: begin
            phase_o <= PH_BIT;
            slot_o  <= '0;
            byte_o  <= '0;
          end
          PH_BIT: begin
            if (slot_o == SLOT_LAST) phase_o <= PH_ACK;
            else                     slot_o  <= slot_o + 1'b1;
          end
          PH_ACK: begin
            if (byte_o == BYTE_LAST) begin
              phase_o <= PH_STOP;
            end else begin
              byte_o  <= byte_o + 1'b1;
              slot_o  <= '0;
              phase_o <= PH_BIT;
            end
          end
          default: phase_o <= PH_STOP;
        endcase
      end
    end
  end

  assign last_o = (phase_o == PH_STOP) && (step_o == LAST_STEP);

endmodule

// File: rtl/pi2c_gap_timer.sv
module pi2c_gap_timer #(
  parameter int unsigned GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic active_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  generate
    if (GAP_CYCLES == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst_n, load_i};
      assign active_o  = 1'b0;
      assign expire_o  = 1'b0;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic             run_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else if (load_i) begin
          cnt_q <= CNT_W'(GAP_CYCLES - 1);
          run_q <= 1'b1;
        end else if (run_q) begin
          if (cnt_q == '0) run_q <= 1'b0;
          else             cnt_q <= cnt_q - 1'b1;
        end
      end
      assign active_o = run_q;
      assign expire_o = run_q && (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/pi2c_reg_encoder.sv
module pi2c_reg_encoder
  import pi2c_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h03,
  parameter logic [7:0]  DEV_BYTE   = 8'h9C,
  parameter logic [7:0]  SUB_BYTE   = 8'h00,
  parameter int unsigned GAP_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] base_i,
  input  logic [7:0]    payload_i,
  input  logic          wr_ready_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o
);
  localparam int unsigned HI_W = DW - 2;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;

  state_t          state_q;
  logic [HI_W-1:0] hi_q;
  logic [7:0]      pay_q;
  logic            done_q;

  phase_t     phase_w;
  logic [1:0] step_w;
  logic [2:0] slot_w;
  logic [1:0] byte_w;
  logic       last_w;
  logic       gap_active_w;
  logic       gap_expire_w;

  // Named internal events used by the checker.
  logic busy_w;
  logic take_start_w;
  logic accept_w;
  logic advance_w;

  assign busy_w       = (state_q != S_IDLE);
  assign take_start_w = (state_q == S_IDLE) && start_i;
  assign accept_w     = (state_q == S_SEND) && wr_ready_i;
  assign advance_w    = accept_w && !last_w;

  pi2c_step_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (take_start_w),
    .advance_i (advance_w),
    .phase_o   (phase_w),
    .step_o    (step_w),
    .slot_o    (slot_w),
    .byte_o    (byte_w),
    .last_o    (last_w)
  );

  pi2c_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (advance_w),
    .active_o (gap_active_w),
    .expire_o (gap_expire_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      hi_q    <= '0;
      pay_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            hi_q    <= base_i[DW-1:2];
            pay_q   <= payload_i;
            state_q <= S_SEND;
          end
        end
        S_SEND: begin
          if (wr_ready_i) begin
            if (last_w) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= (GAP_CYCLES == 0) ? S_SEND : S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (gap_expire_w) state_q <= S_SEND;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic       bit_w;
  logic [1:0] pair_w;

  assign bit_w      = frame_bit(byte_w, slot_w, DEV_BYTE, SUB_BYTE, pay_q);
  assign pair_w     = line_pair(phase_w, step_w, bit_w);
  assign wr_valid_o = (state_q == S_SEND);
  assign wr_addr_o  = REG_ADDR;
  assign wr_data_o  = {hi_q, pair_w};
  assign done_o     = done_q;

endmodule

// File: rtl/pi2c_reg_encoder_chk.sv
module pi2c_reg_encoder_chk #(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h03
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          done,
  input logic          busy,
  input logic          gap_active
);

  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr == REG_ADDR); // R2

  AST_START_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_valid && wr_data[1:0] == 2'b11); // R3

  AST_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wr_data[DW-1:2])); // R8

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> !wr_valid); // R9

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_valid); // R11

endmodule

bind pi2c_reg_encoder pi2c_reg_encoder_chk #(
  .AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid_o),
  .wr_ready   (wr_ready_i),
  .wr_addr    (wr_addr_o),
  .wr_data    (wr_data_o),
  .done       (done_o),
  .busy       (busy_w),
  .gap_active (gap_active_w)
);

// File: tb/pi2c_reg_encoder_test.sv
module pi2c_reg_encoder_test;
  localparam int GAP   = 3;
  localparam int TOTAL = 87;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] base_i = 8'h00;
  logic [7:0] payload_i = 8'h00;
  logic       wr_ready_i = 1'b0;
  logic       wr_valid_o;
  logic [7:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic       done_o;

  always #5 clk = ~clk;

  pi2c_reg_encoder #(.GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .payload_i(payload_i), .wr_ready_i(wr_ready_i), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected register value for write number idx of a frame.
  function automatic logic [7:0] exp_write(logic [7:0] base, logic [7:0] pay, int idx);
    logic [7:0] hi = base & 8'hFC;
    logic [7:0] bytes [3];
    int k, slot, step;
    logic d;
    bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = pay;
    if (idx < 3)   return hi | ((idx == 0) ? 8'h03 : (idx == 1) ? 8'h01 : 8'h00);
    if (idx >= 84) return hi | ((idx == 84) ? 8'h00 : (idx == 85) ? 8'h01 : 8'h03);
    k    = idx - 3;
    slot = (k % 27) / 3;
    step = k % 3;
    d    = (slot < 8) ? bytes[k / 27][7 - slot] : 1'b0;
    return hi | {6'b0, d, step == 1};
  endfunction

  function automatic string tag_of(int idx);
    if (idx < 3)  return "R3";
    if (idx >= 84) return "R7";
    if (((idx - 3) % 27) >= 24) return "R6";
    return "R4";
  endfunction

  // Monitor state
  logic [7:0] exp_base = 8'h00, exp_pay = 8'h00;
  int  widx = 0, lowcnt = 0, done_cnt = 0, pend = 0;
  bit  waiting = 0, prev_stall = 0, mon_en = 0;
  logic [7:0] prev_data = 8'h00;

  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_stall)
        check(wr_valid_o && wr_data_o == prev_data, "R10", "stalled write changed",
              int'(wr_data_o), int'(prev_data));
      if (waiting && wr_valid_o) begin
        check(lowcnt == GAP, "R9", "quiet cycles between writes", lowcnt, GAP);
        waiting = 0;
      end else if (waiting) begin
        lowcnt++;
      end
      if (pend == 2) begin
        check(!done_o, "R11", "done wider than one cycle", int'(done_o), 0);
        pend = 0;
      end else if (pend == 1) begin
        check(done_o, "R11", "done after last write", int'(done_o), 1);
        check(widx == TOTAL, "R5", "writes per frame", widx, TOTAL);
        if (done_o) done_cnt++;
        pend = 2;
      end else if (done_o) begin
        check(0, "R11", "unexpected done", 1, 0);
      end
      if (wr_valid_o)
        check(wr_addr_o == 8'h03, "R2", "write address", int'(wr_addr_o), 3);
      if (wr_valid_o && wr_ready_i) begin
        if (widx >= TOTAL) begin
          check(0, "R12", "write beyond frame", widx, TOTAL - 1);
        end else begin
          check(wr_data_o == exp_write(exp_base, exp_pay, widx), tag_of(widx),
                $sformatf("write %0d data", widx), int'(wr_data_o),
                int'(exp_write(exp_base, exp_pay, widx)));
          check(wr_data_o[7:2] == exp_base[7:2], "R8", "upper bits",
                int'(wr_data_o[7:2]), int'(exp_base[7:2]));
        end
        widx++;
        if (widx == TOTAL) pend = 1;
        else begin waiting = 1; lowcnt = 0; end
      end
      prev_stall = wr_valid_o && !wr_ready_i;
      prev_data  = wr_data_o;
    end
  end

  int ready_mode = 0;
  initial begin
    forever begin
      @(posedge clk); #1;
      wr_ready_i = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  task automatic run_txn(logic [7:0] base, logic [7:0] pay, bit poke);
    int d0 = done_cnt;
    exp_base = base; exp_pay = pay; widx = 0;
    @(posedge clk); #1;
    start_i = 1'b1; base_i = base; payload_i = pay;
    @(posedge clk); #1;
    start_i = 1'b0; base_i = ~base; payload_i = $urandom;
    if (poke) begin
      repeat (30) @(posedge clk);
      #1; start_i = 1'b1; base_i = base ^ 8'h5A; payload_i = ~pay;
      @(posedge clk); #1; start_i = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (8) begin
      @(negedge clk);
      check(!wr_valid_o, "R12", "write after done", int'(wr_valid_o), 0);
    end
  endtask

  initial begin
    forever begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check(!wr_valid_o, "R1", "valid in reset", int'(wr_valid_o), 0);
    check(!done_o, "R1", "done in reset", int'(done_o), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!wr_valid_o, "R1", "valid after reset", int'(wr_valid_o), 0);
    check(!done_o, "R1", "done after reset", int'(done_o), 0);
    mon_en = 1;
    // Directed corners
    run_txn(8'h00, 8'h00, 0);
    run_txn(8'hFF, 8'hFF, 0);
    ready_mode = 1;
    run_txn(8'hA4, 8'hA5, 1);   // R12: start while busy
    run_txn(8'h03, 8'h81, 0);
    // Random frames
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = $urandom;
      logic [7:0] p = $urandom;
      run_txn(b, p, (i % 2) == 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule